// File: doc/BRIEF.md
# MDIO Management Slave

This block is the serial management slave of an Ethernet PHY. It watches the bidirectional management data line on each rising edge of the management clock and decodes Clause 22 frames: a run of ones, a start pattern, an opcode, a PHY address and a register address. It then either shifts sixteen data bits out during a read or collects sixteen data bits for a write. The register contents live outside the block and are reached through a small parallel register bus.

The block accepts a preamble as short as a single one bit, which shortens register access. It answers both its own PHY address and the all-zero broadcast address. A read that misses returns all ones; a write that misses is dropped.

The register bus is plain control, with no valid/ready pair and no back-pressure. Read data must be valid in the same cycle in which `reg_rd` is high. A write is applied in the cycle in which `reg_wr` is high. The serial frame has no cycle in which it could stall, so neither side can stall the other.

Top module: `mdio_slave`

## Requirements
- R1: After reset, `mdio_oe`, `reg_wr` and `reg_rd` are low, and the slave waits for a one bit on `mdio_i`.
- R2: Frame detection starts after one or more one bits followed by the start pattern 0 then 1. A one-bit preamble and a 32-bit preamble are both accepted.
- R3: If the first two bits after the preamble are not 0 then 1, the frame is abandoned and the slave hunts for a preamble again. Such a frame causes no write strobe and never drives the line.
- R4: The two opcode bits 1,0 select a read and 0,1 select a write. The patterns 0,0 and 1,1 abandon the frame with no write strobe and no drive.
- R5: The frame is serviced when its 5-bit PHY address, sent MSB first, equals `OWN_ADDR` (default 1) or is 0 (broadcast). Any other address produces no write strobe.
- R6: On a read, `mdio_oe` stays low during the first turnaround bit. It is high with `mdio_o` = 0 during the second turnaround bit. It then stays high for 16 bit periods of data, MSB first, with each bit changing after a rising edge. It is low again in the bit period after the last data bit.
- R7: A read whose register is not valid (`reg_valid` low), or whose PHY address misses, returns 16'hFFFF on the line.
- R8: On a write, `reg_wr` is high for exactly one cycle, the cycle after the sixteenth data bit is sampled. In that cycle `reg_addr` holds the 5-bit register address and `reg_wdata` holds the data as sent MSB first. The strobe is raised only when the address matches and `reg_valid` is high.
- R9: On a read, `reg_rd` is high for exactly the first turnaround bit period. `reg_rdata` is captured at the end of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every action happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Data driven onto the line while enabled |
| mdio_oe | output | 1 | Line driver enable |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Write data, valid while `reg_wr` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | Read request; `reg_rdata` is captured at its end |
| reg_rdata | input | 16 | Register value for `reg_addr` |
| reg_valid | input | 1 | High when `reg_addr` names an existing register |

## Verification
The write strobe of one frame falls in the same cycle as the first preamble bit of the next frame. The bench provokes this by starting each following frame immediately, with no idle gap, and often with a one-bit preamble. It judges the overlap by checking `reg_wr`, `reg_addr` and `reg_wdata` in that cycle, and later by reading the register back over the serial line against a bench model. Random frames mix broadcast, own and foreign addresses with existing and missing registers. Directed frames with bad start or opcode patterns must leave the strobe and line-driver counters unchanged.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SOF,
    ST_OPC,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_RDAT,
    ST_WDAT
  } mdio_state_e;
endpackage

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_slave_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned OWN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic              reg_valid,
  output mdio_state_e       state_o,
  output logic              is_rd,
  output logic              hit,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              ld,
  output logic              sh_in,
  output logic              sh_out,
  output logic              wr_pulse
);
  localparam int unsigned HDR_W   = 2 * ADDR_W;
  localparam int unsigned CNT_MAX = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX);

  mdio_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic              op_hi;
  logic [HDR_W-1:0]  hdr;
  logic [ADDR_W-1:0] phy;

  assign phy      = hdr[HDR_W-1:ADDR_W];
  assign reg_addr = hdr[ADDR_W-1:0];
  assign hit      = (phy == ADDR_W'(OWN_ADDR)) || (phy == '0);
  assign state_o  = state;
  assign ld       = (state == ST_TA1) && is_rd;
  assign sh_in    = (state == ST_WDAT);
  assign sh_out   = (state == ST_RDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_hi    <= 1'b0;
      is_rd    <= 1'b0;
      hdr      <= '0;
      wr_pulse <= 1'b0;
    end else begin
      wr_pulse <= 1'b0;
      case (state)
        ST_IDLE: if (mdio_in) state <= ST_PRE;
        ST_PRE:  if (!mdio_in) state <= ST_SOF;
        ST_SOF: begin
          cnt   <= '0;
          state <= mdio_in ? ST_OPC : ST_IDLE;
        end
        ST_OPC: begin
          if (cnt == '0) begin
            op_hi <= mdio_in;
            cnt   <= CNT_W'(1);
          end else begin
            cnt <= '0;
            if (op_hi != mdio_in) begin
              is_rd <= op_hi;
              state <= ST_HDR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_HDR: begin
          hdr <= {hdr[HDR_W-2:0], mdio_in};
          if (cnt == CNT_W'(HDR_W - 1)) begin
            cnt   <= '0;
            state <= ST_TA1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TA1: state <= ST_TA2;
        ST_TA2: begin
          cnt   <= '0;
          state <= is_rd ? ST_RDAT : ST_WDAT;
        end
        ST_RDAT: begin
          if (cnt == CNT_W'(DATA_W - 1)) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        ST_WDAT: begin
          if (cnt == CNT_W'(DATA_W - 1)) begin
            state    <= ST_IDLE;
            wr_pulse <= hit && reg_valid;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: strobe lasts one cycle and needs a valid register at the deciding edge
  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  a_r8_wr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(reg_valid));
  // R9: read request lasts one cycle
  a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !ld);
  // R3/R4: header decoding only after a start pattern and a legal opcode
  a_r4_hdr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR && $past(state) != ST_HDR) |-> $past(state) == ST_OPC);
endmodule

// File: rtl/mdio_data_shift.sv
module mdio_data_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              sh_in,
  input  logic              sh_out,
  input  logic              din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (ld)     q <= ld_val;
    else if (sh_in)  q <= {q[DATA_W-2:0], din};
    else if (sh_out) q <= {q[DATA_W-2:0], 1'b1};
  end

  // R6: control never asks for two shift actions in one cycle
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, sh_in, sh_out}));
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned OWN_ADDR = 1
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_valid
);
  mdio_state_e       state;
  logic              is_rd, hit, ld, sh_in, sh_out;
  logic [DATA_W-1:0] shreg, ld_val;

  mdio_frame_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_ADDR(OWN_ADDR)
  ) u_ctl (
    .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_i), .reg_valid(reg_valid),
    .state_o(state), .is_rd(is_rd), .hit(hit), .reg_addr(reg_addr),
    .ld(ld), .sh_in(sh_in), .sh_out(sh_out), .wr_pulse(reg_wr)
  );

  assign ld_val = (hit && reg_valid) ? reg_rdata : '1;

  mdio_data_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(mdc), .rst_n(rst_n), .ld(ld), .ld_val(ld_val),
    .sh_in(sh_in), .sh_out(sh_out), .din(mdio_i), .q(shreg)
  );

  assign reg_rd    = ld;
  assign reg_wdata = shreg;
  assign mdio_oe   = is_rd && (state == ST_TA2 || state == ST_RDAT);
  assign mdio_o    = (state == ST_RDAT) ? shreg[DATA_W-1] : 1'b0;

  // R6: second turnaround bit is a driven zero
  a_r6_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R9: a read request is followed by driving the line
  a_r9_rd_then_drive: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |=> mdio_oe);
  // R7: a missing register reads back as ones from its first data bit
  a_r7_miss_ones: assert property (@(posedge mdc) disable iff (!rst_n)
    (reg_rd && !reg_valid) |=> ##1 mdio_o);
  // R1/R6: never write and drive at once
  a_r1_no_wr_while_drive: assert property (@(posedge mdc) disable iff (!rst_n)
    !(reg_wr && mdio_oe));
endmodule

// File: tb/tb_mdio_slave.sv
module tb_mdio_slave;
  localparam int OWN = 1;
  localparam int NREG = 8;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_valid;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  int oe_seen = 0;
  logic [15:0] rf [NREG];
  logic [15:0] model [NREG];

  always #5 mdc = ~mdc;

  mdio_slave dut (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_valid(reg_valid)
  );

  // Test register file: registers 0..7 exist
  assign reg_valid = (reg_addr < 5'(NREG));
  assign reg_rdata = reg_valid ? rf[reg_addr[2:0]] : 16'h1234;

  always_ff @(posedge mdc) begin
    if (reg_wr && reg_valid) rf[reg_addr[2:0]] <= reg_wdata;
  end

  always @(negedge mdc) begin
    if (reg_wr) wr_seen++;
    if (mdio_oe) oe_seen++;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [4:0] phy);
    return (phy == 5'(OWN)) || (phy == 5'd0);
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] ra);
    if (exp_hit(phy) && ra < 5'(NREG)) return model[ra[2:0]];
    return 16'hFFFF;
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic frame(input int pre, input logic rd, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] got;
    logic ok;
    ok = exp_hit(phy) && (ra < 5'(NREG));
    for (int i = 0; i < pre; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(rd);
    drive_bit(!rd);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
    if (rd) begin
      @(negedge mdc);
      mdio_i = 1'b1;
      check("R6 ta1 released", 16'(mdio_oe), 16'h0);
      check("R9 rd strobe", 16'(reg_rd), 16'h1);
      @(negedge mdc);
      check("R6 ta2 driven zero", {14'h0, mdio_oe, mdio_o}, 16'h2);
      got = '0;
      for (int i = 0; i < 16; i++) begin
        @(negedge mdc);
        if (!mdio_oe) check("R6 oe during data", 16'h0, 16'h1);
        got = {got[14:0], mdio_o};
      end
      check(ok ? "R5 read data" : "R7 miss all ones", got, exp_read(phy, ra));
      @(negedge mdc);
      check("R6 release after data", 16'(mdio_oe), 16'h0);
    end else begin
      drive_bit(1'b1);
      drive_bit(1'b0);
      for (int i = 15; i >= 0; i--) drive_bit(wd[i]);
      @(negedge mdc);
      mdio_i = 1'b1;
      check("R8 wr strobe", 16'(reg_wr), 16'(ok));
      if (ok) begin
        check("R8 wr addr", 16'(reg_addr), 16'(ra));
        check("R8 wr data", reg_wdata, wd);
        model[ra[2:0]] = wd;
      end
    end
  endtask

  task automatic junk(input logic [3:0] head, input string req);
    int w0, o0;
    w0 = wr_seen;
    o0 = oe_seen;
    for (int i = 0; i < 3; i++) drive_bit(1'b1);
    for (int i = 3; i >= 0; i--) drive_bit(head[i]);
    for (int i = 0; i < 30; i++) drive_bit(1'b0);
    @(negedge mdc);
    check(req, 16'(wr_seen - w0 + oe_seen - o0), 16'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) begin
      rf[i] = 16'h0;
      model[i] = 16'h0;
    end
    repeat (3) @(negedge mdc);
    check("R1 reset outputs", {13'h0, mdio_oe, reg_wr, reg_rd}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge mdc);
    check("R1 idle after reset", {13'h0, mdio_oe, reg_wr, reg_rd}, 16'h0);

    // R2: short and full preambles
    frame(1, 1'b0, 5'd1, 5'd3, 16'hA5C3);
    frame(32, 1'b1, 5'd1, 5'd3, 16'h0);
    frame(32, 1'b0, 5'd1, 5'd4, 16'h8001);
    frame(1, 1'b1, 5'd1, 5'd4, 16'h0);
    // R5: broadcast and foreign addresses
    frame(1, 1'b0, 5'd0, 5'd5, 16'h7E11);
    frame(1, 1'b1, 5'd1, 5'd5, 16'h0);
    frame(1, 1'b0, 5'd9, 5'd5, 16'hDEAD);
    frame(1, 1'b1, 5'd0, 5'd5, 16'h0);
    frame(1, 1'b1, 5'd9, 5'd5, 16'h0);
    // R7/R8: missing register
    frame(2, 1'b0, 5'd1, 5'd20, 16'h1111);
    frame(2, 1'b1, 5'd1, 5'd20, 16'h0);
    // R3 bad start, R4 bad opcodes
    junk(4'b0010, "R3 bad start ignored");
    junk(4'b0111, "R4 opcode 11 ignored");
    junk(4'b0100, "R4 opcode 00 ignored");
    frame(1, 1'b1, 5'd1, 5'd3, 16'h0);

    for (int n = 0; n < 60; n++) begin
      logic [4:0] phy, ra;
      int sel, pre;
      sel = $urandom_range(0, 3);
      phy = (sel == 0) ? 5'd0 : (sel == 3) ? 5'($urandom_range(2, 31)) : 5'd1;
      ra  = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 7));
      pre = ($urandom_range(0, 1) == 0) ? 1 : $urandom_range(1, 32);
      frame(pre, 1'($urandom_range(0, 1)), phy, ra, 16'($urandom()));
    end
    for (int i = 0; i < NREG; i++) frame(1, 1'b1, 5'd1, 5'(i), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule